// File: doc/BRIEF.md
# Time-Triggered Bus Slot Scheduler

This block is the per-node controller for a shared serial broadcast line that several control units use in turn. Time on the line is split into rounds, and each round has a fixed number of slots. In a slot that the node owns, it shifts its send buffer onto the line. In every other slot it releases the line to the idle level and samples it into its receive buffer. After the last slot of a round the node waits on an idle line. A dedicated synchronization frame restarts the round at slot 0, and every node then runs its own cycle count for the rest of that round.

One node per system is built with the master parameter set. The master sends the synchronization frame: first after a startup delay following reset, then after a fixed gap at the end of each round. Every other node waits after reset until it has decoded a valid frame. Ownership of the slots comes from a table input with one node ID per slot. A node owns a slot when the entry for that slot equals its own ID parameter.

The line is wired-AND: the idle (recessive) level is 1, and the bus seen by every node is the AND of all node drives. Each slot is a lead guard of `GUARD_CYC` cycles, then `DATA_W` data bits of `BIT_CYC` cycles each, sent MSB first, then a trailing guard of `GUARD_CYC` cycles. Listeners sample each bit at cycle `BIT_CYC/2` of that bit.

Top module: `tt_slot_sched`

## Requirements
- R1: While reset is low and on the cycle after it, `bus_tx_o` is 1, `slot_done_o` is 0, `slot_idx_o` is 0 and `rx_buf_o` is 0.
- R2: With `IS_MASTER` set, the synchronization frame starts exactly `STARTUP_CYC` cycles after reset is released. The frame is 9 bits of `BIT_CYC` cycles each: a 0 start bit, then 0xA5 MSB first.
- R3: Slot 0 begins on the cycle after the frame ends, and each slot lasts `2*GUARD_CYC + DATA_W*BIT_CYC` cycles. `slot_done_o` is high only on the last cycle of each slot, and `slot_idx_o` shows the slot index 0..NUM_SLOTS-1 in increasing order. A non-master node that decodes the frame keeps the same cycle alignment as the master.
- R4: In an owned slot the node drives data bit k (MSB first) for the k-th `BIT_CYC` window after the lead guard. In the guards, and in every slot it does not own, `bus_tx_o` is 1.
- R5: On the cycle after `slot_done_o`, for a slot the node did not own, `rx_buf_o` equals the owner's `tx_buf_i` as sampled on the first cycle of that slot. At all other times `rx_buf_o` holds its value.
- R6: After a slot the node owns, `rx_buf_o` is unchanged.
- R7: A slot whose table entry matches no node leaves the line idle, and every node then receives all ones.
- R8: After the last slot the node returns to slot index 0 and waits with the line idle. The master sends the next frame `GAP_CYC` cycles after the last slot ends.
- R9: A non-master node that sees a frame with a start bit of 0 but a pattern other than 0xA5 stays waiting and produces no `slot_done_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Local clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| bus_rx_i | input | 1 | Resolved serial line level |
| own_tab_i | input | NUM_SLOTS*ID_W | Owner ID of slot s in bits [s*ID_W +: ID_W] |
| tx_buf_i | input | DATA_W | Send buffer |
| bus_tx_o | output | 1 | Line drive, 1 = released/idle |
| rx_buf_o | output | DATA_W | Receive buffer |
| slot_idx_o | output | $clog2(NUM_SLOTS) | Current slot index |
| slot_done_o | output | 1 | High on the last cycle of each slot |

## Verification
The properties assume that the slot table is stable for a whole round. They also assume that exactly one node has `IS_MASTER` set and that any other 0 on the line comes in whole bit windows. The bench wires three nodes through a wired-AND bus. It keeps the table constant and injects one corrupt frame only during the master's startup delay, so the injection never overlaps the master's own transmission. Send buffers change only partway through the lead guard. This tests that capture happens on the first slot cycle without disturbing any data bit.

// File: rtl/tt_sched_pkg.sv
package tt_sched_pkg;

    typedef enum logic [1:0] {
        ST_WAIT,
        ST_SYNC,
        ST_SLOT
    } sched_st_e;

    typedef enum logic [1:0] {
        PH_LEAD,
        PH_DATA,
        PH_TRAIL
    } slot_ph_e;

    localparam logic [7:0] SYNC_PATTERN = 8'hA5;
    localparam int unsigned SYNC_BITS = 9;

endpackage

// File: rtl/tt_owner_sel.sv
module tt_owner_sel #(
    parameter int unsigned NUM_SLOTS = 4,
    parameter int unsigned ID_W      = 3,
    parameter int unsigned NODE_ID   = 0,
    localparam int unsigned SLOT_W   = $clog2(NUM_SLOTS)
) (
    input  logic [NUM_SLOTS*ID_W-1:0] own_tab_i,
    input  logic [SLOT_W-1:0]         slot_i,
    output logic                      hit_o
);

    logic [NUM_SLOTS-1:0] match;

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_match
        assign match[g] = (own_tab_i[g*ID_W +: ID_W] == ID_W'(NODE_ID));
    end

    assign hit_o = match[slot_i];

endmodule

// File: rtl/tt_shifter.sv
module tt_shifter #(
    parameter int unsigned W = 8
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    input  logic         shift_i,
    input  logic         in_bit_i,
    output logic [W-1:0] q_o
);

    logic [W-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = sh_q;
        if (load_i) begin
            sh_d = load_val_i;
        end else if (shift_i) begin
            sh_d = {sh_q[W-2:0], in_bit_i};
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            sh_q <= '0;
        end else begin
            sh_q <= sh_d;
        end
    end

    assign q_o = sh_q;

endmodule

// File: rtl/tt_slot_sched.sv
module tt_slot_sched
    import tt_sched_pkg::*;
#(
    parameter int unsigned NUM_SLOTS   = 4,
    parameter int unsigned ID_W        = 3,
    parameter int unsigned NODE_ID     = 0,
    parameter bit          IS_MASTER   = 1'b0,
    parameter int unsigned DATA_W      = 8,
    parameter int unsigned BIT_CYC     = 4,
    parameter int unsigned GUARD_CYC   = 4,
    parameter int unsigned STARTUP_CYC = 64,
    parameter int unsigned GAP_CYC     = 20,
    localparam int unsigned SLOT_W     = $clog2(NUM_SLOTS)
) (
    input  logic                      clk_i,
    input  logic                      rst_ni,
    input  logic                      bus_rx_i,
    input  logic [NUM_SLOTS*ID_W-1:0] own_tab_i,
    input  logic [DATA_W-1:0]         tx_buf_i,
    output logic                      bus_tx_o,
    output logic [DATA_W-1:0]         rx_buf_o,
    output logic [SLOT_W-1:0]         slot_idx_o,
    output logic                      slot_done_o
);

    localparam int unsigned SH_W   = (DATA_W > 8) ? DATA_W : 8;
    localparam int unsigned MAXC_A = (STARTUP_CYC > GAP_CYC) ? STARTUP_CYC : GAP_CYC;
    localparam int unsigned MAXC_B = (GUARD_CYC > BIT_CYC) ? GUARD_CYC : BIT_CYC;
    localparam int unsigned MAXC   = (MAXC_A > MAXC_B) ? MAXC_A : MAXC_B;
    localparam int unsigned CNT_W  = $clog2(MAXC + 1);
    localparam int unsigned MAXB   = (DATA_W > SYNC_BITS) ? DATA_W : SYNC_BITS;
    localparam int unsigned BIDX_W = $clog2(MAXB + 1);

    localparam logic [CNT_W-1:0]  BIT_LAST   = CNT_W'(BIT_CYC - 1);
    localparam logic [CNT_W-1:0]  BIT_MID    = CNT_W'(BIT_CYC / 2);
    localparam logic [CNT_W-1:0]  GUARD_LAST = CNT_W'(GUARD_CYC - 1);
    localparam logic [CNT_W-1:0]  START_LAST = CNT_W'(STARTUP_CYC - 1);
    localparam logic [CNT_W-1:0]  GAP_LAST   = CNT_W'(GAP_CYC - 1);
    localparam logic [BIDX_W-1:0] SYNC_LAST  = BIDX_W'(SYNC_BITS - 1);
    localparam logic [BIDX_W-1:0] DATA_LAST  = BIDX_W'(DATA_W - 1);
    localparam logic [SLOT_W-1:0] SLOT_LAST  = SLOT_W'(NUM_SLOTS - 1);

    typedef struct packed {
        sched_st_e          st;
        slot_ph_e           ph;
        logic [CNT_W-1:0]   cnt;
        logic [BIDX_W-1:0]  bidx;
        logic [SLOT_W-1:0]  slot;
        logic               own;
        logic               first;
        logic               bad;
        logic [DATA_W-1:0]  rx;
    } ctl_t;

    ctl_t cur_q, nxt_d;

    logic            owner_hit;
    logic            sh_load, sh_shift, sh_in;
    logic [SH_W-1:0] sh_q;
    logic            sync_bit;
    logic            done;
    logic            chk_listen, chk_guard;

    tt_owner_sel #(
        .NUM_SLOTS (NUM_SLOTS),
        .ID_W      (ID_W),
        .NODE_ID   (NODE_ID)
    ) u_owner (
        .own_tab_i (own_tab_i),
        .slot_i    (cur_q.slot),
        .hit_o     (owner_hit)
    );

    tt_shifter #(
        .W (SH_W)
    ) u_shift (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .load_i     (sh_load),
        .load_val_i (SH_W'(tx_buf_i)),
        .shift_i    (sh_shift),
        .in_bit_i   (sh_in),
        .q_o        (sh_q)
    );

    // Frame bit for the current sync bit index: start bit 0, then the pattern MSB first
    always_comb begin
        int pidx;
        pidx = 8 - int'(cur_q.bidx);
        if (cur_q.bidx == '0) begin
            sync_bit = 1'b0;
        end else begin
            sync_bit = SYNC_PATTERN[pidx[2:0]];
        end
    end

    always_comb begin
        nxt_d    = cur_q;
        sh_load  = 1'b0;
        sh_shift = 1'b0;
        sh_in    = bus_rx_i;
        done     = 1'b0;
        unique case (cur_q.st)
            ST_WAIT: begin
                nxt_d.slot = '0;
                if (IS_MASTER) begin
                    if (cur_q.cnt == (cur_q.first ? START_LAST : GAP_LAST)) begin
                        nxt_d.st    = ST_SYNC;
                        nxt_d.cnt   = '0;
                        nxt_d.bidx  = '0;
                        nxt_d.first = 1'b0;
                    end else begin
                        nxt_d.cnt = cur_q.cnt + 1'b1;
                    end
                end else if (!bus_rx_i) begin
                    // falling edge seen: this cycle is cycle 0 of the start bit
                    nxt_d.st   = ST_SYNC;
                    nxt_d.cnt  = CNT_W'(1);
                    nxt_d.bidx = '0;
                    nxt_d.bad  = 1'b0;
                end
            end
            ST_SYNC: begin
                if (!IS_MASTER && cur_q.cnt == BIT_MID) begin
                    sh_shift = 1'b1;
                    if (cur_q.bidx == '0 && bus_rx_i) begin
                        nxt_d.bad = 1'b1;
                    end
                end
                if (cur_q.cnt == BIT_LAST) begin
                    nxt_d.cnt = '0;
                    if (cur_q.bidx == SYNC_LAST) begin
                        if (IS_MASTER || (!cur_q.bad && sh_q[7:0] == SYNC_PATTERN)) begin
                            nxt_d.st   = ST_SLOT;
                            nxt_d.ph   = PH_LEAD;
                            nxt_d.slot = '0;
                        end else begin
                            nxt_d.st = ST_WAIT;
                        end
                    end else begin
                        nxt_d.bidx = cur_q.bidx + 1'b1;
                    end
                end else begin
                    nxt_d.cnt = cur_q.cnt + 1'b1;
                end
            end
            ST_SLOT: begin
                unique case (cur_q.ph)
                    PH_LEAD: begin
                        if (cur_q.cnt == '0) begin
                            nxt_d.own = owner_hit;
                            sh_load   = owner_hit;
                        end
                        if (cur_q.cnt == GUARD_LAST) begin
                            nxt_d.ph   = PH_DATA;
                            nxt_d.cnt  = '0;
                            nxt_d.bidx = '0;
                        end else begin
                            nxt_d.cnt = cur_q.cnt + 1'b1;
                        end
                    end
                    PH_DATA: begin
                        if (!cur_q.own && cur_q.cnt == BIT_MID) begin
                            sh_shift = 1'b1;
                        end
                        if (cur_q.own && cur_q.cnt == BIT_LAST) begin
                            sh_shift = 1'b1;
                            sh_in    = 1'b1;
                        end
                        if (cur_q.cnt == BIT_LAST) begin
                            nxt_d.cnt = '0;
                            if (cur_q.bidx == DATA_LAST) begin
                                nxt_d.ph = PH_TRAIL;
                            end else begin
                                nxt_d.bidx = cur_q.bidx + 1'b1;
                            end
                        end else begin
                            nxt_d.cnt = cur_q.cnt + 1'b1;
                        end
                    end
                    default: begin
                        if (cur_q.cnt == GUARD_LAST) begin
                            done      = 1'b1;
                            nxt_d.cnt = '0;
                            if (!cur_q.own) begin
                                nxt_d.rx = sh_q[DATA_W-1:0];
                            end
                            if (cur_q.slot == SLOT_LAST) begin
                                nxt_d.st   = ST_WAIT;
                                nxt_d.slot = '0;
                            end else begin
                                nxt_d.slot = cur_q.slot + 1'b1;
                                nxt_d.ph   = PH_LEAD;
                            end
                        end else begin
                            nxt_d.cnt = cur_q.cnt + 1'b1;
                        end
                    end
                endcase
            end
            default: nxt_d.st = ST_WAIT;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            cur_q.st    <= ST_WAIT;
            cur_q.ph    <= PH_LEAD;
            cur_q.cnt   <= '0;
            cur_q.bidx  <= '0;
            cur_q.slot  <= '0;
            cur_q.own   <= 1'b0;
            cur_q.first <= 1'b1;
            cur_q.bad   <= 1'b0;
            cur_q.rx    <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    always_comb begin
        bus_tx_o = 1'b1;
        if (IS_MASTER && cur_q.st == ST_SYNC) begin
            bus_tx_o = sync_bit;
        end else if (cur_q.st == ST_SLOT && cur_q.ph == PH_DATA && cur_q.own) begin
            bus_tx_o = sh_q[DATA_W-1];
        end
    end

    assign rx_buf_o    = cur_q.rx;
    assign slot_idx_o  = cur_q.slot;
    assign slot_done_o = done;
    assign chk_listen  = (cur_q.st == ST_SLOT) && !cur_q.own;
    assign chk_guard   = (cur_q.st == ST_SLOT) && (cur_q.ph != PH_DATA);

endmodule

// File: rtl/tt_slot_sched_chk.sv
module tt_slot_sched_chk #(
    parameter int unsigned NUM_SLOTS = 4,
    parameter int unsigned DATA_W    = 8,
    localparam int unsigned SLOT_W   = $clog2(NUM_SLOTS)
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              bus_tx_i,
    input logic              done_i,
    input logic [SLOT_W-1:0] idx_i,
    input logic [DATA_W-1:0] rx_i,
    input logic              listen_i,
    input logic              guard_i
);

    localparam logic [SLOT_W-1:0] IDX_LAST = SLOT_W'(NUM_SLOTS - 1);

    assert_guard_idle_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        guard_i |-> bus_tx_i);

    assert_listen_quiet_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        listen_i |-> bus_tx_i);

    assert_done_single_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_i |=> !done_i);

    assert_idx_range_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        idx_i <= IDX_LAST);

    assert_idx_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (done_i && idx_i != IDX_LAST) |=> (idx_i == $past(idx_i) + 1'b1));

    assert_wrap_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (done_i && idx_i == IDX_LAST) |=> (idx_i == '0));

    assert_rx_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !done_i |=> $stable(rx_i));

    assert_owned_keep_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (done_i && !listen_i) |=> $stable(rx_i));

endmodule

bind tt_slot_sched tt_slot_sched_chk #(
    .NUM_SLOTS (NUM_SLOTS),
    .DATA_W    (DATA_W)
) chk_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .bus_tx_i (bus_tx_o),
    .done_i   (slot_done_o),
    .idx_i    (slot_idx_o),
    .rx_i     (rx_buf_o),
    .listen_i (chk_listen),
    .guard_i  (chk_guard)
);

// File: tb/tt_slot_sched_tb.sv
module tt_slot_sched_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NS    = 4;
    localparam int IDW   = 3;
    localparam int DW    = 8;
    localparam int BC    = 4;
    localparam int GC    = 4;
    localparam int START = 64;
    localparam int GAP   = 20;
    localparam int SC    = 2 * GC + DW * BC;
    localparam int SYNC_LEN = 9 * BC;
    localparam int RND   = SYNC_LEN + NS * SC + GAP;
    localparam int BAD_AT = 4;
    localparam logic [7:0] BAD_PAT = 8'h5A;
    localparam logic [7:0] GOOD_PAT = 8'hA5;
    // slot0 -> node 0, slot1 -> node 2, slot2 -> node 1, slot3 -> id 7 (nobody)
    localparam logic [NS*IDW-1:0] TAB = {3'd7, 3'd1, 3'd2, 3'd0};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic inj = 1'b1;
    logic bus;
    logic [DW-1:0] tx_buf [3];
    logic [DW-1:0] rx [3];
    logic [1:0] idx [3];
    logic done [3];
    logic tx [3];
    int cyc = 0;
    int n_chk = 0;
    int n_err = 0;
    bit running = 1'b0;
    logic [DW-1:0] exp_rx [3];
    logic [DW-1:0] cap = '0;
    int cap_own = 7;

    always #(CLK_PERIOD / 2) clk = ~clk;

    assign bus = tx[0] & tx[1] & tx[2] & inj;

    tt_slot_sched #(.NUM_SLOTS(NS), .ID_W(IDW), .NODE_ID(0), .IS_MASTER(1'b1), .DATA_W(DW),
        .BIT_CYC(BC), .GUARD_CYC(GC), .STARTUP_CYC(START), .GAP_CYC(GAP)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .bus_rx_i(bus), .own_tab_i(TAB), .tx_buf_i(tx_buf[0]),
        .bus_tx_o(tx[0]), .rx_buf_o(rx[0]), .slot_idx_o(idx[0]), .slot_done_o(done[0]));

    tt_slot_sched #(.NUM_SLOTS(NS), .ID_W(IDW), .NODE_ID(1), .IS_MASTER(1'b0), .DATA_W(DW),
        .BIT_CYC(BC), .GUARD_CYC(GC), .STARTUP_CYC(START), .GAP_CYC(GAP)) node1_i (
        .clk_i(clk), .rst_ni(rst_n), .bus_rx_i(bus), .own_tab_i(TAB), .tx_buf_i(tx_buf[1]),
        .bus_tx_o(tx[1]), .rx_buf_o(rx[1]), .slot_idx_o(idx[1]), .slot_done_o(done[1]));

    tt_slot_sched #(.NUM_SLOTS(NS), .ID_W(IDW), .NODE_ID(2), .IS_MASTER(1'b0), .DATA_W(DW),
        .BIT_CYC(BC), .GUARD_CYC(GC), .STARTUP_CYC(START), .GAP_CYC(GAP)) node2_i (
        .clk_i(clk), .rst_ni(rst_n), .bus_rx_i(bus), .own_tab_i(TAB), .tx_buf_i(tx_buf[2]),
        .bus_tx_o(tx[2]), .rx_buf_o(rx[2]), .slot_idx_o(idx[2]), .slot_done_o(done[2]));

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s at cycle %0d: actual %0h expected %0h", req, cyc, act, exp);
        end
    endtask

    function automatic int slot_owner(input int s);
        return int'(TAB[s*IDW +: IDW]);
    endfunction

    always @(posedge clk) if (rst_n) cyc <= cyc + 1;

    // Reference model evaluated on every falling edge
    always @(negedge clk) begin
        if (running) begin
            int o, p, s, q, b;
            bit in_round, exp_done, exp_bus;
            o = cyc - START;
            in_round = 1'b0;
            exp_done = 1'b0;
            exp_bus = 1'b1;
            s = 0;
            p = 0;
            // R5/R6: receive buffers compared every cycle
            for (int n = 0; n < 3; n++) begin
                chk(rx[n] === exp_rx[n], (n == cap_own) ? "R6" : "R5", int'(rx[n]), int'(exp_rx[n]));
            end
            if (o >= 0) begin
                o = o % RND;
                if (o < SYNC_LEN) begin
                    b = o / BC;
                    exp_bus = (b == 0) ? 1'b0 : GOOD_PAT[8 - b];
                    chk(bus === exp_bus, "R2", int'(bus), int'(exp_bus));
                end else if (o < SYNC_LEN + NS * SC) begin
                    in_round = 1'b1;
                    p = o - SYNC_LEN;
                    s = p / SC;
                    q = p % SC;
                    exp_done = (q == SC - 1);
                    if (q == 0) begin
                        cap_own = slot_owner(s);
                        cap = (cap_own < 3) ? tx_buf[cap_own] : 8'hFF;
                    end
                    if (q >= GC && q < GC + DW * BC && cap_own < 3) begin
                        exp_bus = cap[DW - 1 - (q - GC) / BC];
                    end
                    chk(bus === exp_bus, (cap_own < 3) ? "R4" : "R7", int'(bus), int'(exp_bus));
                end else begin
                    chk(bus === 1'b1, "R8", int'(bus), 1);
                end
            end
            for (int n = 0; n < 3; n++) begin
                chk(done[n] === exp_done, (cyc < START + SYNC_LEN) ? "R9" : "R3", int'(done[n]), int'(exp_done));
                if (in_round) chk(idx[n] === 2'(s), "R3", int'(idx[n]), s);
                else if (o >= 0) chk(idx[n] === 2'd0, "R8", int'(idx[n]), 0);
            end
            if (exp_done) begin
                for (int n = 0; n < 3; n++) if (n != cap_own) exp_rx[n] = cap;
            end
            if (in_round && (p % SC) == 3) begin
                for (int n = 0; n < 3; n++) tx_buf[n] = 8'($urandom);
            end
            // R9: a corrupt frame during the master's startup delay
            if (cyc >= BAD_AT && cyc < BAD_AT + SYNC_LEN) begin
                b = (cyc - BAD_AT) / BC;
                inj = (b == 0) ? 1'b0 : BAD_PAT[8 - b];
            end else begin
                inj = 1'b1;
            end
        end
    end

    initial begin
        tx_buf[0] = 8'h3C;
        tx_buf[1] = 8'hC3;
        tx_buf[2] = 8'h81;
        for (int n = 0; n < 3; n++) exp_rx[n] = '0;
        repeat (3) @(negedge clk);
        for (int n = 0; n < 3; n++) begin
            chk(tx[n] === 1'b1 && done[n] === 1'b0, "R1", int'({tx[n], done[n]}), 2);
            chk(idx[n] === 2'd0 && rx[n] === 8'h00, "R1", int'({idx[n], rx[n]}), 0);
        end
        rst_n = 1'b1;
        running = 1'b1;
        wait (cyc >= START + 3 * RND + 5);
        @(negedge clk);
        running = 1'b0;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        n_chk++;
        n_err++;
        $display("FAIL watchdog expired at cycle %0d: actual hung expected done", cyc);
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule